// File: doc/BRIEF.md
# Two-Stage Gated Card Clock Divider

This block derives the clocks for a storage-card interface from a parent clock. The division runs in two cascaded stages: a source stage that divides by a power of two (1, 2, 4, 8 or 16), followed by a final stage that divides the source-stage output by 2 or 4. The total ratio is the product of the two stages, so it ranges from 2 to 64. The block produces two single-cycle clock-enable outputs in the parent domain. The high-speed enable marks each period of the source-stage output. The card enable marks each period of the total division.

A single control register holds the two divider fields and two stop bits, one for each enable output. Software writes the register through a one-cycle write strobe and can always read it back. A new divider setting never cuts an output period short: the period in progress completes with the old ratio, and the new ratio starts at the next period boundary. Stop bits act at once and can be set without touching the divider fields.

Top module: `card_clk_div`

## Requirements
- R1: After reset the register reads 0x301 (both stop bits set, source code 0, final code 1), and both enables stay low.
- R2: Register bit 9 is the high-speed stop, bit 8 is the card stop, bits 4:2 are the source code and bits 1:0 are the final code. These bits read back as last written. Bits 7:5 always read 0.
- R3: With its stop bit clear, hs_en is high for one cycle every S parent cycles. S is 1, 2, 4, 8 or 16 for source codes 0 to 4. Source codes 5, 6 and 7 give 16.
- R4: With its stop bit clear, card_en is high for one cycle every S*F parent cycles. F is 2 for final code 0 and 4 for final code 1. Final codes 2 and 3 give 4.
- R5: Whenever card_en is high and the high-speed stop bit is clear, hs_en is high in the same cycle. Each card period contains exactly F high-speed pulses.
- R6: A 1 in a stop bit holds its own enable low. The other enable keeps running unchanged.
- R7: When a write sets a stop bit, the matching enable is low from the parent cycle that follows the write edge.
- R8: A divider change takes effect at a period boundary. The card period in progress when the write lands still lasts its old length, and the next period uses the new ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parent clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe, one cycle |
| wr_data | input | 10 | Register write value |
| hs_en | output | 1 | High-speed clock enable pulse |
| card_en | output | 1 | Card clock enable pulse |
| rd_data | output | 10 | Register readback |

## Verification
The assertions assume that wr_en and wr_data hold defined values from the first clock after reset. They also assume that only the register write changes the divider and stop state, so every decoded setting stays within the legal range after the reserved codes are folded. The stimulus writes only at falling edges with a single-cycle strobe. It draws random source codes from the full 0 to 7 range and random final codes from the full 0 to 3 range, so the reserved codes are covered. After each divider change the bench discards the partial period before it measures the new ratio.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;
  localparam int REG_W         = 10;
  localparam int STOP_HS_BIT   = 9;
  localparam int STOP_CARD_BIT = 8;
  localparam int SRC_LSB       = 2;
  localparam int SRC_W         = 3;
  localparam int FIN_LSB       = 0;
  localparam int FIN_W         = 2;
  localparam int SRC_MAX_L2    = 4;
  localparam int FIN_MIN_L2    = 1;
  localparam int FIN_MAX_L2    = 2;
  localparam int L2_W          = 3;
  localparam int CNT_W         = SRC_MAX_L2 + FIN_MAX_L2;
  localparam logic [REG_W-1:0] RST_VAL   = 10'h301;
  localparam logic [REG_W-1:0] KEEP_MASK = 10'h31F;

  typedef struct packed {
    logic [L2_W-1:0] src_l2;
    logic [L2_W-1:0] fin_l2;
  } div_cfg_t;

  // Fold reserved codes onto the largest legal divider of each stage.
  function automatic div_cfg_t decode_cfg(input logic [REG_W-1:0] r);
    div_cfg_t c;
    logic [SRC_W-1:0] s;
    logic [FIN_W-1:0] f;
    s = r[SRC_LSB +: SRC_W];
    f = r[FIN_LSB +: FIN_W];
    c.src_l2 = (int'(s) > SRC_MAX_L2) ? L2_W'(SRC_MAX_L2) : L2_W'(s);
    c.fin_l2 = (f == '0) ? L2_W'(FIN_MIN_L2) : L2_W'(FIN_MAX_L2);
    return c;
  endfunction
endpackage

// File: rtl/cdiv_ctrl_reg.sv
module cdiv_ctrl_reg
  import cdiv_pkg::*;
#(
  parameter int                W       = REG_W,
  parameter logic [REG_W-1:0]  INIT    = RST_VAL,
  parameter logic [REG_W-1:0]  WR_MASK = KEEP_MASK
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] ctrl_q,
  output logic [W-1:0] ctrl_nxt
);
  always_comb ctrl_nxt = wr_en ? (wr_data & WR_MASK) : ctrl_q;

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= INIT;
    else     ctrl_q <= ctrl_nxt;
  end

  assert_rsv_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q & ~WR_MASK) == '0);
endmodule

// File: rtl/cdiv_counter.sv
module cdiv_counter
  import cdiv_pkg::*;
#(
  parameter int CW = CNT_W,
  parameter int LW = L2_W
) (
  input  logic     clk,
  input  logic     rst,
  input  div_cfg_t next_cfg,
  output logic     src_tick,
  output logic     card_tick
);
  logic [CW-1:0] cnt;
  div_cfg_t      act;
  logic [CW-1:0] src_mask, tot_mask;
  logic [LW-1:0] tot_l2;

  always_comb begin
    tot_l2    = act.src_l2 + act.fin_l2;
    src_mask  = ~({CW{1'b1}} << act.src_l2);
    tot_mask  = ~({CW{1'b1}} << tot_l2);
    src_tick  = (cnt & src_mask) == src_mask;
    card_tick = cnt == tot_mask;
  end

  // The active setting is only reloaded when a full output period ends.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      act <= decode_cfg(RST_VAL);
    end else if (card_tick) begin
      cnt <= '0;
      act <= next_cfg;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assert_cnt_range_R4: assert property (@(posedge clk) disable iff (rst)
    cnt <= tot_mask);
  assert_switch_boundary_R8: assert property (@(posedge clk) disable iff (rst)
    !$stable(act) |-> cnt == '0);
  assert_card_has_src_R5: assert property (@(posedge clk) disable iff (rst)
    card_tick |-> src_tick);
endmodule

// File: rtl/cdiv_gate.sv
module cdiv_gate #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] tick,
  input  logic [N-1:0] stop,
  output logic [N-1:0] en
);
  for (genvar i = 0; i < N; i++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst) en[i] <= 1'b0;
      else     en[i] <= tick[i] & ~stop[i];
    end

    assert_stop_now_R7: assert property (@(posedge clk) disable iff (rst)
      $past(stop[i]) |-> !en[i]);
  end
endmodule

// File: rtl/card_clk_div.sv
module card_clk_div
  import cdiv_pkg::*;
#(
  parameter int W = REG_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic         hs_en,
  output logic         card_en,
  output logic [W-1:0] rd_data
);
  localparam int NCH = 2;

  logic [W-1:0]   ctrl_q, ctrl_nxt;
  div_cfg_t       cfg_nxt;
  logic           src_tick, card_tick;
  logic [NCH-1:0] ticks, stops, ens;

  cdiv_ctrl_reg #(.W(W)) u_reg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .ctrl_q(ctrl_q), .ctrl_nxt(ctrl_nxt)
  );

  always_comb cfg_nxt = decode_cfg(ctrl_nxt);

  cdiv_counter u_cnt (
    .clk(clk), .rst(rst), .next_cfg(cfg_nxt),
    .src_tick(src_tick), .card_tick(card_tick)
  );

  always_comb begin
    ticks = {card_tick, src_tick};
    stops = {ctrl_nxt[STOP_CARD_BIT], ctrl_nxt[STOP_HS_BIT]};
  end

  cdiv_gate #(.N(NCH)) u_gate (
    .clk(clk), .rst(rst), .tick(ticks), .stop(stops), .en(ens)
  );

  assign hs_en   = ens[0];
  assign card_en = ens[1];
  assign rd_data = ctrl_q;

  assert_card_with_hs_R5: assert property (@(posedge clk) disable iff (rst)
    (card_en && !ctrl_q[STOP_HS_BIT]) |-> hs_en);
  assert_card_stopped_R6: assert property (@(posedge clk) disable iff (rst)
    ctrl_q[STOP_CARD_BIT] |-> !card_en);
  assert_hs_stopped_R6: assert property (@(posedge clk) disable iff (rst)
    ctrl_q[STOP_HS_BIT] |-> !hs_en);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> (!hs_en && !card_en));
endmodule

// File: tb/sim_card_clk_div.sv
module sim_card_clk_div;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [9:0] wr_data = '0;
  logic       hs_en, card_en;
  logic [9:0] rd_data;
  int total = 0, bad = 0, cycles = 0;

  card_clk_div u0 (.*);

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      bad = bad + 1; total = total + 1;
      $display("FAIL watchdog: actual=%0d expected<150000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic int exp_src(input int code);
    return (code > 4) ? 16 : (1 << code);
  endfunction
  function automatic int exp_fin(input int code);
    return (code == 0) ? 2 : 4;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Counts cycles up to and including the next card pulse, and hs pulses seen.
  task automatic next_card(output int cyc, output int hs_n);
    cyc = 0; hs_n = 0;
    do begin
      @(negedge clk);
      cyc++;
      if (hs_en) hs_n++;
    end while (!card_en && cyc < 300);
  endtask

  task automatic count_win(input int n, output int hs_n, output int cd_n);
    hs_n = 0; cd_n = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (hs_en) hs_n++;
      if (card_en) cd_n++;
    end
  endtask

  initial begin
    int c, h, hn, cn;
    logic [9:0] d;
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset readback", int'(rd_data), 'h301);
    count_win(30, hn, cn);
    check("R1 hs quiet", hn, 0);
    check("R1 card quiet", cn, 0);

    // Readback with reserved bits
    wr(10'h3FF);
    check("R2 reserved bits read zero", int'(rd_data), 'h31F);
    wr(10'h313);
    check("R2 stop without field change", int'(rd_data), 'h313);
    wr(10'h013);
    check("R2 enable keeps fields", int'(rd_data), 'h013);
    next_card(c, h);
    next_card(c, h);
    check("R4 reserved codes divide by 64", c, 64);
    check("R5 hs pulses per card period", h, 4);

    // Random settings
    for (int it = 0; it < 24; it++) begin
      int s, f;
      s = $urandom_range(0, 7);
      f = $urandom_range(0, 3);
      d = {2'b00, 3'b000, 3'(s), 2'(f)};
      wr(d);
      check("R2 random readback", int'(rd_data), int'(d));
      next_card(c, h);
      for (int k = 0; k < 2; k++) begin
        next_card(c, h);
        check("R4 card period", c, exp_src(s) * exp_fin(f));
        check("R5 hs per card", h, exp_fin(f));
      end
      count_win(exp_src(s) * 4, hn, cn);
      check("R3 hs rate", hn, 4);
    end

    // Old period completes before new ratio applies
    wr(10'h011);
    next_card(c, h);
    next_card(c, h);
    repeat (5) @(negedge clk);
    wr(10'h000);
    next_card(c, h);
    check("R8 old period finishes", c + 6, 64);
    next_card(c, h);
    check("R8 new period applies", c, 2);

    // Independent stops
    wr(10'h104);
    count_win(40, hn, cn);
    check("R6 card stopped", cn, 0);
    check("R6 hs still runs", hn, 20);
    wr(10'h204);
    count_win(40, hn, cn);
    check("R6 hs stopped", hn, 0);
    check("R6 card still runs", cn, 10);

    // Immediate stop
    wr(10'h000);
    repeat (4) @(negedge clk);
    check("R3 source code 0 every cycle", int'(hs_en), 1);
    wr(10'h200);
    check("R7 hs low after stop write", int'(hs_en), 0);
    wr(10'h000);
    repeat (4) @(negedge clk);
    if (!card_en) @(negedge clk);
    wr(10'h100);
    @(negedge clk);
    check("R7 card low after stop write", int'(card_en), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule